// File: doc/BRIEF.md
# Debug Transport Test Access Port

This block is the scan-side entry point of an on-chip debug path. A debugger clocks it through four pins (test clock, mode select, serial data in, serial data out). It runs the complete sixteen-state test-access-port controller and a five-bit instruction register. The instruction register chooses which data register sits between the serial input and output.

Three data registers hold content. A fixed 32-bit identification word identifies the chip. A 32-bit transport control word tells the debugger the transport version and the width of the debug-bus address. A 40-bit debug-bus access register lets the debugger issue read and write requests towards a debug module. Every other instruction code selects a one-bit bypass stage.

The debug module is represented by a small stub. It answers every read with a fixed dummy word. The result of a read becomes visible in the next capture of the debug-bus register.

Top module: `dbg_tap_top`

## Requirements
- R1: On each rising test-clock edge the controller follows the standard sixteen-state graph under the mode-select pin. Shift and Pause states hold while mode select is 0. Five consecutive 1s on mode select reach Test-Logic-Reset from any state, via Select-IR-Scan with mode select 1.
- R2: A synchronous high `rst` sampled on a rising edge forces Test-Logic-Reset. After reset, `tdo_en` and `tdo` are 0, and the active instruction is the identification code 5'h01.
- R3: The instruction register is 5 bits. Capture-IR loads 5'b00001. Shift-IR shifts it towards `tdo` with `tdi` entering bit 4. The new code takes effect in Update-IR, and being in Test-Logic-Reset reloads 5'h01.
- R4: Instruction 5'h01 selects a 32-bit register that captures 32'hDEADBEEF.
- R5: Instruction 5'h10 selects a 32-bit register that captures the transport version 1 in bits [3:0] and the debug-bus address width 6 in bits [9:4], giving 32'h00000061.
- R6: Instruction 5'h11 selects a 40-bit register with address in [39:34], data in [33:2] and op in [1:0]. Capture-DR loads the last latched address and data with op 0 (success).
- R7: In Update-DR, op 1 (read) latches the shifted address and stores the stub's dummy word 32'hD0D0CAFE as the data.
- R8: In Update-DR, op 2 (write) latches the shifted address and leaves the data unchanged. Ops 0 and 3 change neither address nor data.
- R9: Every other instruction, including 5'h1F and 5'h05, selects a 1-bit bypass register that captures 0, so the output is the input delayed by one bit.
- R10: Data leaves least significant bit first. `tdo` changes on the falling test-clock edge. `tdo_en` is 1 only in Shift-DR and Shift-IR, and `tdo` is 0 whenever `tdo_en` is 0.
- R11: A Shift-DR sequence interrupted by Exit1-DR, Pause-DR and Exit2-DR continues without losing or repeating a bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset, sampled on rising `tck` |
| tms | input | 1 | Mode select, steers the controller |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_en | output | 1 | High while a shift state drives `tdo` |

## Verification
On every clock edge, the assertions check these rules:
- the controller's hold and return transitions;
- the capture pattern of the instruction register;
- the reload of the identification instruction in Test-Logic-Reset;
- the success code placed in the op field at debug-bus capture;
- the rule that `tdo_en` appears only in shift states, with `tdo` quiet otherwise.

Other behaviour shows only in the bench's scan sequences:
- the register contents;
- least-significant-bit-first ordering and falling-edge output timing;
- the one-bit bypass delay;
- that read, write and no-op requests change the following capture correctly;
- that a paused shift resumes intact.

// File: rtl/dtap_pkg.sv
package dtap_pkg;

    localparam int IR_W     = 5;
    localparam int ABITS    = 6;
    localparam int DATA_W   = 32;
    localparam int OP_W     = 2;
    localparam int DBUS_W   = ABITS + DATA_W + OP_W;
    localparam int LEN_W    = $clog2(DBUS_W + 1);
    localparam int VERSION  = 1;

    localparam logic [IR_W-1:0] INS_IDENT = 5'h01;
    localparam logic [IR_W-1:0] INS_CTRL  = 5'h10;
    localparam logic [IR_W-1:0] INS_DBUS  = 5'h11;
    localparam logic [IR_W-1:0] IR_CAPTURE_PAT = 5'b00001;

    localparam logic [DATA_W-1:0] IDENT_WORD = 32'hDEADBEEF;
    localparam logic [DATA_W-1:0] DM_DUMMY   = 32'hD0D0CAFE;
    localparam logic [DATA_W-1:0] CTRL_WORD  =
        {{(DATA_W-10){1'b0}}, ABITS[5:0], VERSION[3:0]};

    localparam logic [OP_W-1:0] OP_NONE  = 2'd0;
    localparam logic [OP_W-1:0] OP_READ  = 2'd1;
    localparam logic [OP_W-1:0] OP_WRITE = 2'd2;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef struct packed {
        logic [ABITS-1:0]  addr;
        logic [DATA_W-1:0] data;
        logic [OP_W-1:0]   op;
    } dbus_word_t;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
        case (s)
            ST_RESET:  return m ? ST_RESET  : ST_IDLE;
            ST_IDLE:   return m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: return m ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  return m ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: return m ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: return m ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: return m ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: return m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: return m ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: return m ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  return m ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: return m ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: return m ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: return m ? ST_UPD_IR : ST_SH_IR;
            default:   return m ? ST_SEL_DR : ST_IDLE;
        endcase
    endfunction

    function automatic logic [LEN_W-1:0] dr_len(input logic [IR_W-1:0] code);
        case (code)
            INS_IDENT, INS_CTRL: return LEN_W'(DATA_W);
            INS_DBUS:            return LEN_W'(DBUS_W);
            default:             return LEN_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/dtap_fsm.sv
module dtap_fsm
    import dtap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e state
);
    always_ff @(posedge tck) begin
        if (rst) state <= ST_RESET;
        else     state <= tap_next(state, tms);
    end
endmodule

// File: rtl/dtap_ir.sv
module dtap_ir
    import dtap_pkg::*;
(
    input  logic            tck,
    input  logic            rst,
    input  logic            tdi,
    input  tap_state_e      state,
    output logic [IR_W-1:0] ir_q,
    output logic [IR_W-1:0] ir_sh
);
    always_ff @(posedge tck) begin
        if (rst) begin
            ir_q  <= INS_IDENT;
            ir_sh <= '0;
        end else begin
            case (state)
                ST_RESET:  ir_q  <= INS_IDENT;
                ST_CAP_IR: ir_sh <= IR_CAPTURE_PAT;
                ST_SH_IR:  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
                ST_UPD_IR: ir_q  <= ir_sh;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dtap_dm_stub.sv
module dtap_dm_stub
    import dtap_pkg::*;
(
    input  logic              rd_req,
    output logic [DATA_W-1:0] rd_data
);
    assign rd_data = rd_req ? DM_DUMMY : '0;
endmodule

// File: rtl/dtap_dr.sv
module dtap_dr
    import dtap_pkg::*;
(
    input  logic              tck,
    input  logic              rst,
    input  logic              tdi,
    input  tap_state_e        state,
    input  logic [IR_W-1:0]   ir_q,
    input  logic [DATA_W-1:0] dm_rdata,
    output logic              dm_rd_req,
    output logic [DBUS_W-1:0] dr_sh
);
    logic [ABITS-1:0]  bus_addr;
    logic [DATA_W-1:0] bus_data;
    logic [DBUS_W-1:0] cap_val;
    logic [DBUS_W-1:0] sh_next;
    logic [LEN_W-1:0]  top_bit;
    dbus_word_t        req;
    logic              upd_bus;

    assign req     = dbus_word_t'(dr_sh);
    assign upd_bus = (state == ST_UPD_DR) && (ir_q == INS_DBUS);
    assign dm_rd_req = upd_bus && (req.op == OP_READ);
    assign top_bit = dr_len(ir_q) - LEN_W'(1);

    always_comb begin
        case (ir_q)
            INS_IDENT: cap_val = DBUS_W'(IDENT_WORD);
            INS_CTRL:  cap_val = DBUS_W'(CTRL_WORD);
            INS_DBUS:  cap_val = {bus_addr, bus_data, OP_NONE};
            default:   cap_val = '0;
        endcase
    end

    always_comb begin
        sh_next = dr_sh >> 1;
        sh_next[top_bit] = tdi;
    end

    always_ff @(posedge tck) begin
        if (rst) begin
            dr_sh    <= '0;
            bus_addr <= '0;
            bus_data <= '0;
        end else begin
            if (state == ST_CAP_DR) dr_sh <= cap_val;
            else if (state == ST_SH_DR) dr_sh <= sh_next;
            if (upd_bus) begin
                if (req.op == OP_READ) begin
                    bus_addr <= req.addr;
                    bus_data <= dm_rdata;
                end else if (req.op == OP_WRITE) begin
                    bus_addr <= req.addr;
                end
            end
        end
    end
endmodule

// File: rtl/dbg_tap_top.sv
module dbg_tap_top
    import dtap_pkg::*;
(
    input  logic tck,
    input  logic rst,
    input  logic tms,
    input  logic tdi,
    output logic tdo,
    output logic tdo_en
);
    tap_state_e        state;
    logic [IR_W-1:0]   ir_q;
    logic [IR_W-1:0]   ir_sh;
    logic [DBUS_W-1:0] dr_sh;
    logic [DATA_W-1:0] dm_rdata;
    logic              dm_rd_req;

    dtap_fsm u_fsm (.tck(tck), .rst(rst), .tms(tms), .state(state));

    dtap_ir u_ir (.tck(tck), .rst(rst), .tdi(tdi), .state(state),
                  .ir_q(ir_q), .ir_sh(ir_sh));

    dtap_dm_stub u_dm (.rd_req(dm_rd_req), .rd_data(dm_rdata));

    dtap_dr u_dr (.tck(tck), .rst(rst), .tdi(tdi), .state(state), .ir_q(ir_q),
                  .dm_rdata(dm_rdata), .dm_rd_req(dm_rd_req), .dr_sh(dr_sh));

    always_ff @(negedge tck) begin
        if (rst) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            case (state)
                ST_SH_DR: begin tdo <= dr_sh[0]; tdo_en <= 1'b1; end
                ST_SH_IR: begin tdo <= ir_sh[0]; tdo_en <= 1'b1; end
                default:  begin tdo <= 1'b0;     tdo_en <= 1'b0; end
            endcase
        end
    end
endmodule

// File: rtl/dtap_checker.sv
module dtap_checker
    import dtap_pkg::*;
(
    input logic              tck,
    input logic              rst,
    input logic              tms,
    input tap_state_e        state,
    input logic [IR_W-1:0]   ir_q,
    input logic [IR_W-1:0]   ir_sh,
    input logic [DBUS_W-1:0] dr_sh,
    input logic              tdo,
    input logic              tdo_en
);
    a_r1_reset_hold: assert property (@(posedge tck) disable iff (rst)
        (state == ST_RESET && tms) |=> state == ST_RESET);

    a_r1_selir_exit: assert property (@(posedge tck) disable iff (rst)
        (state == ST_SEL_IR && tms) |=> state == ST_RESET);

    a_r1_update_idle: assert property (@(posedge tck) disable iff (rst)
        ((state == ST_UPD_DR || state == ST_UPD_IR) && !tms) |=> state == ST_IDLE);

    a_r11_pause_hold: assert property (@(posedge tck) disable iff (rst)
        (state == ST_PAU_DR && !tms) |=> (state == ST_PAU_DR && $stable(dr_sh)));

    a_r3_ir_capture: assert property (@(posedge tck) disable iff (rst)
        state == ST_CAP_IR |=> ir_sh == IR_CAPTURE_PAT);

    a_r3_reset_ident: assert property (@(posedge tck) disable iff (rst)
        state == ST_RESET |=> ir_q == INS_IDENT);

    a_r6_op_success: assert property (@(posedge tck) disable iff (rst)
        (state == ST_CAP_DR && ir_q == INS_DBUS) |=> dr_sh[1:0] == OP_NONE);

    a_r10_en_in_shift: assert property (@(posedge tck) disable iff (rst)
        tdo_en |-> (state == ST_SH_DR || state == ST_SH_IR));

    a_r10_quiet_out: assert property (@(posedge tck) disable iff (rst)
        !tdo_en |-> !tdo);
endmodule

bind dbg_tap_top dtap_checker u_chk (
    .tck(tck), .rst(rst), .tms(tms), .state(state), .ir_q(ir_q),
    .ir_sh(ir_sh), .dr_sh(dr_sh), .tdo(tdo), .tdo_en(tdo_en)
);

// File: tb/dbg_tap_top_tb.sv
module dbg_tap_top_tb;
    logic tck = 1'b0;
    logic rst = 1'b1;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic tdo, tdo_en;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct {
        string      tag;
        logic [39:0] val;
        int         len;
    } exp_t;

    exp_t        exp_q[$];
    logic [39:0] obs_q[$];

    localparam logic [31:0] DUMMY = 32'hD0D0CAFE;

    always #5 tck = ~tck;

    dbg_tap_top u_dut (.tck(tck), .rst(rst), .tms(tms), .tdi(tdi),
                       .tdo(tdo), .tdo_en(tdo_en));

    task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one test clock: drive after the falling edge, sample before the rising edge
    task automatic bit_cyc(input logic m, input logic d, output logic o, output logic e);
        @(negedge tck);
        #1 tms = m; tdi = d;
        #2 o = tdo; e = tdo_en;
    endtask

    task automatic step(input logic m);
        logic o, e;
        bit_cyc(m, 1'b0, o, e);
    endtask

    // from Run-Test/Idle back to Run-Test/Idle through an IR scan
    task automatic scan_ir(input logic [4:0] code);
        logic [4:0] got;
        logic o, e;
        step(1); step(1); step(0); step(0);
        for (int i = 0; i < 5; i++) begin
            bit_cyc(i == 4, code[i], o, e);
            got[i] = o;
        end
        step(1); step(0);
        check("R3 IR capture pattern", {35'd0, got}, 40'h01);
    endtask

    // driver: pushes the expected capture, shifts din, hands the result to the monitor
    task automatic scan_dr(input string tag, input logic [39:0] din, input int len,
                           input logic [39:0] exp);
        logic [39:0] got;
        logic o, e;
        exp_q.push_back('{tag, exp, len});
        got = '0;
        step(1); step(0); step(0);
        for (int i = 0; i < len; i++) begin
            bit_cyc(i == len - 1, din[i], o, e);
            got[i] = o;
        end
        step(1); step(0);
        obs_q.push_back(got);
    endtask

    // monitor: pairs observed scans with expected items
    initial begin
        forever begin
            wait (obs_q.size() > 0);
            begin
                exp_t        ex;
                logic [39:0] ob;
                ex = exp_q.pop_front();
                ob = obs_q.pop_front();
                check(ex.tag, ob, ex.val);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic o, e;
        repeat (4) @(negedge tck);
        #1 rst = 1'b0;
        @(negedge tck);
        #3 check("R2 tdo_en after reset", {39'd0, tdo_en}, 40'd0);
        check("R2 tdo after reset", {39'd0, tdo}, 40'd0);
        step(0);
        scan_dr("R2 R4 default identification", 40'd0, 32, {8'd0, 32'hDEADBEEF});

        scan_ir(5'h10);
        scan_dr("R5 transport control word", 40'd0, 32, 40'h61);

        scan_ir(5'h11);
        scan_dr("R6 dbus initial capture", {6'd5, 32'h12345678, 2'd1}, 40, 40'd0);
        scan_dr("R7 read result", {6'd9, 32'hAAAA5555, 2'd2}, 40, {6'd5, DUMMY, 2'd0});
        scan_dr("R8 write keeps data", {6'd3, 32'h0, 2'd0}, 40, {6'd9, DUMMY, 2'd0});
        scan_dr("R8 op0 no effect", {6'd7, 32'h0, 2'd3}, 40, {6'd9, DUMMY, 2'd0});
        scan_dr("R8 op3 no effect", 40'd0, 40, {6'd9, DUMMY, 2'd0});

        scan_ir(5'h1F);
        scan_dr("R9 bypass all-ones", 40'hA5, 8, 40'h4A);
        scan_ir(5'h05);
        scan_dr("R9 bypass unlisted", 40'h3C, 8, 40'h78);

        // R11: pause in the middle of an identification shift
        scan_ir(5'h01);
        begin
            logic [39:0] got;
            got = '0;
            exp_q.push_back('{"R11 paused shift", {8'd0, 32'hDEADBEEF}, 32});
            step(1); step(0); step(0);
            for (int i = 0; i < 10; i++) begin
                bit_cyc(i == 9, 1'b0, o, e);
                got[i] = o;
            end
            step(0);
            bit_cyc(1'b0, 1'b0, o, e);
            check("R10 tdo_en low in pause", {39'd0, e}, 40'd0);
            step(1); step(0);
            for (int i = 10; i < 32; i++) begin
                bit_cyc(i == 31, 1'b0, o, e);
                got[i] = o;
            end
            step(1); step(0);
            obs_q.push_back(got);
        end

        // R1: five ones from idle reach Test-Logic-Reset, restoring the identification code
        scan_ir(5'h10);
        repeat (5) step(1);
        bit_cyc(1'b0, 1'b0, o, e);
        check("R1 tdo_en low in reset state", {39'd0, e}, 40'd0);
        bit_cyc(1'b0, 1'b0, o, e);
        check("R10 tdo quiet in idle", {38'd0, e, o}, 40'd0);
        scan_dr("R1 R3 ident after five ones", 40'd0, 32, {8'd0, 32'hDEADBEEF});

        // R2: reset in the middle of a control-register shift
        scan_ir(5'h10);
        step(1); step(0); step(0); step(0);
        @(negedge tck); #1 rst = 1'b1;
        @(negedge tck); #1 rst = 1'b0; tms = 1'b0;
        #2 check("R2 reset mid-shift quiets tdo_en", {39'd0, tdo_en}, 40'd0);
        step(0);
        scan_dr("R2 reset restores identification", 40'd0, 32, {8'd0, 32'hDEADBEEF});

        wait (obs_q.size() == 0);
        #1;
        finish_run();
    end
endmodule